// File: doc/BRIEF.md
# Lane-Interleaved Masked Vector Arithmetic Unit

This block runs element-wise integer arithmetic on a small vector register file. Elements are spread over a fixed number of lanes: element i lives in lane i mod LANES. Each cycle, every lane takes the same control and handles one element, so one group of LANES elements is finished per cycle. An instruction gives an operation, a destination, two sources, a broadcast scalar, an active length and a flag that turns on masking. The unit returns a completion count, a read-back port and the mask and overflow-flag registers. A separate element write port lets a load unit fill registers.

Two identical execution slots hold instructions. Each slot is a small state machine with two states. SL_IDLE moves to SL_RUN on the transition start, when an accepted instruction is steered into that slot. SL_RUN stays in SL_RUN on the transition advance, which moves the group counter up by one. SL_RUN returns to SL_IDLE on the transition finish, taken in the cycle that handles the last active group. Each instruction starts at least one cycle after the one before it, and both move at one group per cycle. A newer instruction therefore always reads group g after the older one has written that group. This gives element-granular chaining with no dependency tracking.

Top module: `vx_unit`

## Requirements
- R1: After reset, every register element, the mask and the overflow flags read zero, issue_ready_o is 1 and done_o is 0.
- R2: Element i is computed by lane i mod LANES, with LANES elements per cycle. For an instruction accepted at clock edge E0, done_o counts it in the single cycle between edges E0+n-1 and E0+n, where n = ceil(VL/LANES), or n = 1 when VL = 0.
- R3: op_i encodings: 0 is add vector+vector, 1 is add scalar+vector, 2 is subtract vector-vector, 3 is subtract scalar-vector, 4 is multiply vector×vector, 5 is multiply scalar×vector. For vector-vector forms, A is src_a element i and B is src_b element i. For scalar forms, A is scalar_i and B is src_b element i. The result is A op B, wrapped to W bits, and is written to dst element i.
- R4: Only elements 0 to VL-1 are written. Register, mask and flag elements at index VL or above keep their values. VL = 0 changes nothing.
- R5: A second instruction may be accepted in the cycle right after the first. Its results then match running the two instructions one after the other, even when it reads the first one's destination or its mask.
- R6: op_i 6 writes mask bit i = (signed A < signed B). op_i 7 writes mask bit i = (A == B), with A and B taken from the vector sources. Compares write no vector register and no flag.
- R7: With masked_i = 1, an arithmetic op writes element i only when mask bit i is 1. Other elements keep their register value and flag.
- R8: When a written element's signed result overflows W bits, flag bit i is set. It stays set until reset. The wrapped result is still written.
- R9: issue_ready_o is 0 while both slots are running. An issue_valid_i in such a cycle is ignored.
- R10: When ld_en_i is 1, ld_data_i is written to element ld_idx_i of register ld_reg_i at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid_i | input | 1 | Instruction offered |
| issue_ready_o | output | 1 | A slot is free |
| op_i | input | 3 | Operation code (R3, R6) |
| dst_i | input | RW | Destination register |
| src_a_i | input | RW | First vector source |
| src_b_i | input | RW | Second vector source |
| scalar_i | input | W | Broadcast scalar operand |
| vl_i | input | VLW | Active vector length, 0..MAXVL |
| masked_i | input | 1 | Write only where mask bit is set |
| ld_en_i | input | 1 | Load-port element write enable |
| ld_reg_i | input | RW | Load-port register |
| ld_idx_i | input | IW | Load-port element index |
| ld_data_i | input | W | Load-port data |
| rd_reg_i | input | RW | Read-back register |
| rd_idx_i | input | IW | Read-back element index |
| rd_data_o | output | W | Read-back element value |
| mask_o | output | MAXVL | Mask register |
| flags_o | output | MAXVL | Sticky overflow flags |
| done_o | output | 2 | Instructions completing this cycle |

## Verification
Every operation code is swept against lengths 0, 1, 3, 4, 7 and 16, both unmasked and masked, on fresh random operands and a random mask. The lengths separate the empty case, partial first groups, exact group multiples and a full vector, so they expose off-by-one length handling and wrong latency. Masked and unmasked runs of the same op separate the write gating from the arithmetic. Random full-range operands trip signed overflow often enough to test both setting and stickiness of the flags. A back-to-back pair where the second instruction reads the first one's result, and a compare followed at once by a masked op, tell real element-wise chaining apart from stale reads. A third offer made while both slots are busy must leave all state untouched.

// File: rtl/vx_pkg.sv
`timescale 1ns/1ps
package vx_pkg;
    typedef enum logic [2:0] {
        OP_ADD_VV = 3'd0,
        OP_ADD_SV = 3'd1,
        OP_SUB_VV = 3'd2,
        OP_SUB_SV = 3'd3,
        OP_MUL_VV = 3'd4,
        OP_MUL_SV = 3'd5,
        OP_CMP_LT = 3'd6,
        OP_CMP_EQ = 3'd7
    } vop_e;

    typedef enum logic {
        SL_IDLE = 1'b0,
        SL_RUN  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/vx_lane_alu.sv
`timescale 1ns/1ps
module vx_lane_alu
    import vx_pkg::*;
#(
    parameter int W = 8
) (
    input  vop_e         op,
    input  logic [W-1:0] va,
    input  logic [W-1:0] vb,
    input  logic [W-1:0] sc,
    output logic [W-1:0] res,
    output logic         ovf,
    output logic         cbit
);
    logic signed [W-1:0]   sa;
    logic signed [W-1:0]   sb;
    logic        [W:0]     ext;
    logic signed [2*W-1:0] prod;

    always_comb begin
        sa   = (op == OP_ADD_SV || op == OP_SUB_SV || op == OP_MUL_SV) ? sc : va;
        sb   = vb;
        prod = (2*W)'(sa) * (2*W)'(sb);
        ext  = '0;
        res  = '0;
        ovf  = 1'b0;
        cbit = 1'b0;
        unique case (op)
            OP_ADD_VV, OP_ADD_SV: begin
                ext = {sa[W-1], sa} + {sb[W-1], sb};
                res = ext[W-1:0];
                ovf = ext[W] ^ ext[W-1];
            end
            OP_SUB_VV, OP_SUB_SV: begin
                ext = {sa[W-1], sa} - {sb[W-1], sb};
                res = ext[W-1:0];
                ovf = ext[W] ^ ext[W-1];
            end
            OP_MUL_VV, OP_MUL_SV: begin
                res = prod[W-1:0];
                ovf = !((&prod[2*W-1:W-1]) || !(|prod[2*W-1:W-1]));
            end
            OP_CMP_LT: cbit = (sa < sb);
            OP_CMP_EQ: cbit = (sa == sb);
        endcase
    end
endmodule

// File: rtl/vx_slot.sv
`timescale 1ns/1ps
module vx_slot
    import vx_pkg::*;
#(
    parameter int LANES = 4,
    parameter int GW    = 2,
    parameter int VLW   = 5,
    parameter int PW    = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [VLW-1:0] vl_i,
    input  logic [PW-1:0]  pay_i,
    output logic           run_o,
    output logic           last_o,
    output logic [GW-1:0]  grp_o,
    output logic [VLW-1:0] vl_o,
    output logic [PW-1:0]  pay_o
);
    slot_state_e    state_q, state_d;
    logic [GW-1:0]  grp_q, grp_d;
    logic [VLW-1:0] vl_q;
    logic [PW-1:0]  pay_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SL_IDLE;
            grp_q   <= '0;
            vl_q    <= '0;
            pay_q   <= '0;
        end else begin
            state_q <= state_d;
            grp_q   <= grp_d;
            if (start_i) begin
                vl_q  <= vl_i;
                pay_q <= pay_i;
            end
        end
    end

    // transitions: start, advance, finish
    always_comb begin
        state_d = state_q;
        grp_d   = grp_q;
        unique case (state_q)
            SL_IDLE: if (start_i) begin
                state_d = SL_RUN;
                grp_d   = '0;
            end
            SL_RUN: begin
                if (last_o) state_d = SL_IDLE;
                else        grp_d   = grp_q + 1'b1;
            end
        endcase
    end

    // outputs
    always_comb begin
        run_o  = (state_q == SL_RUN);
        last_o = run_o && (int'(grp_q) * LANES + LANES >= int'(vl_q));
        grp_o  = grp_q;
        vl_o   = vl_q;
        pay_o  = pay_q;
    end

    // R2: one group per cycle until the last one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !last_o) |=> (run_o && grp_q == $past(grp_q) + 1'b1));
    // R2: slot is free right after its last group
    p_finish_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (state_q == SL_IDLE));
    // R9: the issue steering never starts a busy slot
    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (state_q == SL_IDLE));
endmodule

// File: rtl/vx_unit.sv
`timescale 1ns/1ps
module vx_unit
    import vx_pkg::*;
#(
    parameter int W     = 8,
    parameter int LANES = 4,
    parameter int MAXVL = 16,
    parameter int NREG  = 4,
    parameter int RW    = $clog2(NREG),
    parameter int IW    = $clog2(MAXVL),
    parameter int VLW   = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid_i,
    output logic             issue_ready_o,
    input  logic [2:0]       op_i,
    input  logic [RW-1:0]    dst_i,
    input  logic [RW-1:0]    src_a_i,
    input  logic [RW-1:0]    src_b_i,
    input  logic [W-1:0]     scalar_i,
    input  logic [VLW-1:0]   vl_i,
    input  logic             masked_i,
    input  logic             ld_en_i,
    input  logic [RW-1:0]    ld_reg_i,
    input  logic [IW-1:0]    ld_idx_i,
    input  logic [W-1:0]     ld_data_i,
    input  logic [RW-1:0]    rd_reg_i,
    input  logic [IW-1:0]    rd_idx_i,
    output logic [W-1:0]     rd_data_o,
    output logic [MAXVL-1:0] mask_o,
    output logic [MAXVL-1:0] flags_o,
    output logic [1:0]       done_o
);
    localparam int GROUPS = MAXVL / LANES;
    localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int PW     = 3 + 3 * RW + W + 1;
    localparam int NSLOT  = 2;

    logic [W-1:0]     rf [NREG][MAXVL];
    logic [MAXVL-1:0] mask_q, flags_q;
    logic             young_q;

    logic             run  [NSLOT];
    logic             last [NSLOT];
    logic             start[NSLOT];
    logic [GW-1:0]    grp  [NSLOT];
    logic [VLW-1:0]   svl  [NSLOT];
    logic [PW-1:0]    spay [NSLOT];
    logic [2:0]       s_op [NSLOT];
    logic [RW-1:0]    s_dst[NSLOT];
    logic [RW-1:0]    s_a  [NSLOT];
    logic [RW-1:0]    s_b  [NSLOT];
    logic [W-1:0]     s_sc [NSLOT];
    logic             s_msk[NSLOT];

    logic             w_en  [NSLOT][LANES];
    logic             m_en  [NSLOT][LANES];
    logic [IW-1:0]    e_idx [NSLOT][LANES];
    logic [W-1:0]     e_res [NSLOT][LANES];
    logic             e_ovf [NSLOT][LANES];
    logic             e_cbit[NSLOT][LANES];
    logic             m_any;

    logic [PW-1:0] pay_in;
    logic          accept;

    assign pay_in        = {op_i, dst_i, src_a_i, src_b_i, scalar_i, masked_i};
    assign issue_ready_o = !run[0] || !run[1];
    assign accept        = issue_valid_i && issue_ready_o;
    assign start[0]      = accept && !run[0];
    assign start[1]      = accept && run[0];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        vx_slot #(.LANES(LANES), .GW(GW), .VLW(VLW), .PW(PW)) u_slot (
            .clk(clk), .rst_n(rst_n), .start_i(start[s]), .vl_i(vl_i),
            .pay_i(pay_in), .run_o(run[s]), .last_o(last[s]), .grp_o(grp[s]),
            .vl_o(svl[s]), .pay_o(spay[s])
        );
        assign {s_op[s], s_dst[s], s_a[s], s_b[s], s_sc[s], s_msk[s]} = spay[s];

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [IW-1:0] idx;
            logic [W-1:0]  res;
            logic          ovf, cbit, act, is_cmp;

            // lane l always handles elements congruent to l mod LANES
            assign idx    = IW'(int'(grp[s]) * LANES + l);
            assign act    = run[s] && (int'(idx) < int'(svl[s]));
            assign is_cmp = (s_op[s][2:1] == 2'b11);

            vx_lane_alu #(.W(W)) u_alu (
                .op(vop_e'(s_op[s])), .va(rf[s_a[s]][idx]), .vb(rf[s_b[s]][idx]),
                .sc(s_sc[s]), .res(res), .ovf(ovf), .cbit(cbit)
            );

            assign w_en[s][l]   = act && !is_cmp && (!s_msk[s] || mask_q[idx]);
            assign m_en[s][l]   = act && is_cmp;
            assign e_idx[s][l]  = idx;
            assign e_res[s][l]  = res;
            assign e_ovf[s][l]  = ovf;
            assign e_cbit[s][l] = cbit;
        end
    end

    always_comb begin
        m_any = 1'b0;
        for (int s = 0; s < NSLOT; s++)
            for (int l = 0; l < LANES; l++)
                m_any = m_any | m_en[s][l];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf      <= '{default: '0};
            mask_q  <= '0;
            flags_q <= '0;
            young_q <= 1'b0;
        end else begin
            if (start[0])      young_q <= 1'b0;
            else if (start[1]) young_q <= 1'b1;
            if (ld_en_i) rf[ld_reg_i][ld_idx_i] <= ld_data_i;
            for (int s = 0; s < NSLOT; s++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (w_en[s][l]) begin
                        rf[s_dst[s]][e_idx[s][l]] <= e_res[s][l];
                        if (e_ovf[s][l]) flags_q[e_idx[s][l]] <= 1'b1;
                    end
                    if (m_en[s][l]) mask_q[e_idx[s][l]] <= e_cbit[s][l];
                end
            end
        end
    end

    assign rd_data_o = rf[rd_reg_i][rd_idx_i];
    assign mask_o    = mask_q;
    assign flags_o   = flags_q;
    assign done_o    = {1'b0, last[0]} + {1'b0, last[1]};

    // R5: the younger instruction trails the older by at least one group
    p_chain_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run[0] && run[1]) |-> (grp[young_q] < grp[!young_q]));
    // R8: overflow flags never clear
    p_flags_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
    // R6: mask changes only when a compare writes it
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !m_any |=> $stable(mask_q));
endmodule

// File: tb/sim_vx_unit.sv
`timescale 1ns/1ps
module sim_vx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid_i = 1'b0;
    logic        issue_ready_o;
    logic [2:0]  op_i = '0;
    logic [1:0]  dst_i = '0, src_a_i = '0, src_b_i = '0;
    logic [7:0]  scalar_i = '0;
    logic [4:0]  vl_i = '0;
    logic        masked_i = 1'b0;
    logic        ld_en_i = 1'b0;
    logic [1:0]  ld_reg_i = '0;
    logic [3:0]  ld_idx_i = '0;
    logic [7:0]  ld_data_i = '0;
    logic [1:0]  rd_reg_i = '0;
    logic [3:0]  rd_idx_i = '0;
    logic [7:0]  rd_data_o;
    logic [15:0] mask_o, flags_o;
    logic [1:0]  done_o;

    vx_unit u0 (
        .clk(clk), .rst_n(rst_n), .issue_valid_i(issue_valid_i), .issue_ready_o(issue_ready_o),
        .op_i(op_i), .dst_i(dst_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .scalar_i(scalar_i),
        .vl_i(vl_i), .masked_i(masked_i), .ld_en_i(ld_en_i), .ld_reg_i(ld_reg_i),
        .ld_idx_i(ld_idx_i), .ld_data_i(ld_data_i), .rd_reg_i(rd_reg_i), .rd_idx_i(rd_idx_i),
        .rd_data_o(rd_data_o), .mask_o(mask_o), .flags_o(flags_o), .done_o(done_o)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    logic [7:0]  mrf [4][16];
    logic [15:0] mmask, mflags;
    logic [31:0] seed = 32'h1234_5678;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[23:16];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 4; r++)
            for (int i = 0; i < 16; i++) mrf[r][i] = '0;
        mmask = '0;
        mflags = '0;
    endtask

    // R10: element writes through the load port
    task automatic load_reg(input int r, input int copy_from);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] d;
            d = rnd();
            if (copy_from >= 0 && d[0]) d = mrf[copy_from][i];
            @(negedge clk);
            ld_en_i = 1'b1; ld_reg_i = 2'(r); ld_idx_i = 4'(i); ld_data_i = d;
            mrf[r][i] = d;
        end
        @(negedge clk);
        ld_en_i = 1'b0;
    endtask

    task automatic model(input int op, input int dst, input int a, input int b,
                         input logic [7:0] sc, input int vl, input bit msk);
        for (int i = 0; i < vl; i++) begin
            logic [7:0] av, bv;
            int sa, sb, r;
            bit sv;
            sv = (op == 1 || op == 3 || op == 5);
            av = sv ? sc : mrf[a][i];
            bv = mrf[b][i];
            sa = int'($signed(av));
            sb = int'($signed(bv));
            if (op == 6) mmask[i] = (sa < sb);
            else if (op == 7) mmask[i] = (sa == sb);
            else if (!msk || mmask[i]) begin
                if (op < 2) r = sa + sb;
                else if (op < 4) r = sa - sb;
                else r = sa * sb;
                mrf[dst][i] = r[7:0];
                if (r > 127 || r < -128) mflags[i] = 1'b1;
            end
        end
    endtask

    task automatic check_state(input string req);
        for (int r = 0; r < 4; r++)
            for (int i = 0; i < 16; i++) begin
                rd_reg_i = 2'(r); rd_idx_i = 4'(i);
                #1;
                chk(req, int'(rd_data_o), int'(mrf[r][i]));
            end
        chk({req, " R6 mask"}, int'(mask_o), int'(mmask));
        chk({req, " R8 flags"}, int'(flags_o), int'(mflags));
    endtask

    task automatic issue(input int op, input int dst, input int a, input int b,
                         input logic [7:0] sc, input int vl, input bit msk);
        int n;
        @(negedge clk);
        chk("R9 ready when idle", int'(issue_ready_o), 1);
        issue_valid_i = 1'b1; op_i = 3'(op); dst_i = 2'(dst); src_a_i = 2'(a);
        src_b_i = 2'(b); scalar_i = sc; vl_i = 5'(vl); masked_i = msk;
        @(negedge clk);
        issue_valid_i = 1'b0;
        n = 1;
        while (done_o == 2'd0 && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk($sformatf("R2 latency op%0d vl%0d", op, vl), n, (vl == 0) ? 1 : (vl + 3) / 4);
        @(negedge clk);
        chk("R2 done one cycle", int'(done_o), 0);
        model(op, dst, a, b, sc, vl, msk);
    endtask

    initial begin
        int ops [8] = '{6, 0, 1, 2, 3, 4, 5, 7};
        int vls [6] = '{0, 1, 3, 4, 7, 16};
        int dsum;
        do_reset();
        @(negedge clk);
        chk("R1 ready after reset", int'(issue_ready_o), 1);
        chk("R1 done after reset", int'(done_o), 0);
        check_state("R1 reset state");

        // R3 R4 R6 R7 R8 sweep
        foreach (ops[k]) begin
            foreach (vls[j]) begin
                for (int m = 0; m < 2; m++) begin
                    do_reset();
                    load_reg(1, -1);
                    load_reg(2, 1);
                    issue(6, 0, 1, 2, 8'd0, 16, 1'b0);
                    load_reg(1, -1);
                    load_reg(2, 1);
                    issue(ops[k], (m == 0) ? 3 : 1, 1, 2, rnd(), vls[j], m[0]);
                    check_state($sformatf("R3/R4/R7 op%0d vl%0d msk%0d", ops[k], vls[j], m));
                end
            end
        end

        // R5 back-to-back chained pair, R9 third offer while both busy
        do_reset();
        load_reg(1, -1);
        load_reg(2, -1);
        @(negedge clk);
        issue_valid_i = 1'b1; op_i = 3'd0; dst_i = 2'd3; src_a_i = 2'd1; src_b_i = 2'd2;
        vl_i = 5'd16; masked_i = 1'b0;
        @(negedge clk);
        chk("R5 ready for second", int'(issue_ready_o), 1);
        op_i = 3'd4; dst_i = 2'd0; src_a_i = 2'd3; src_b_i = 2'd1;
        dsum = int'(done_o);
        @(negedge clk);
        chk("R9 ready low both busy", int'(issue_ready_o), 0);
        op_i = 3'd3; dst_i = 2'd1; src_a_i = 2'd0; src_b_i = 2'd2; scalar_i = 8'd77;
        dsum += int'(done_o);
        @(negedge clk);
        issue_valid_i = 1'b0;
        for (int c = 0; c < 8; c++) begin
            dsum += int'(done_o);
            @(negedge clk);
        end
        chk("R5 completions", dsum, 2);
        model(0, 3, 1, 2, 8'd0, 16, 1'b0);
        model(4, 0, 3, 1, 8'd0, 16, 1'b0);
        check_state("R5/R9 chain");

        // R5 compare chained into masked op on the next cycle
        load_reg(1, -1);
        load_reg(2, 1);
        @(negedge clk);
        issue_valid_i = 1'b1; op_i = 3'd6; dst_i = 2'd0; src_a_i = 2'd1; src_b_i = 2'd2;
        vl_i = 5'd13; masked_i = 1'b0;
        @(negedge clk);
        op_i = 3'd1; dst_i = 2'd3; src_a_i = 2'd0; src_b_i = 2'd2; scalar_i = 8'd100;
        vl_i = 5'd16; masked_i = 1'b1;
        @(negedge clk);
        issue_valid_i = 1'b0;
        repeat (8) @(negedge clk);
        model(6, 0, 1, 2, 8'd0, 13, 1'b0);
        model(1, 3, 0, 2, 8'd100, 16, 1'b1);
        check_state("R5/R7 mask chain");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule